// File: doc/BRIEF.md
# Indirect Guest Register Bridge

This block lets a host with a 32-bit memory-mapped port reach the internal registers of several small 8-bit peripheral chips. The chips share one local byte-wide bus. The host sees a single command/status word. Writing that word starts one bus cycle on the local bus. The cycle either loads a register offset into the offset latch of the chosen chip, or reads or writes a data byte at the offset that was loaded last. While the cycle runs, the word reports a busy flag. When a read completes, the byte it fetched is returned in the low byte of the same word.

A full register access therefore takes two commands: one that loads the offset, then one that transfers the data. Software waits for the busy flag to drop between commands. Burst transfers to a chip's FIFO repeat the offset/data pair for every byte. On the second chip, the second channel's registers are reached by adding 0x40 to the first channel's offset. The bridge also collects interrupt requests from the chips into one sticky flag, which the host clears by writing a fixed key word.

The local bus cycle is built from a fixed sequence. First comes one setup clock, in which chip select and the register-select line become valid. Next the read or write strobe is held low for a parameter number of clocks. Last comes one hold clock, in which the select lines stay valid and the strobe is released.

Top module: `gxb_bridge`

## Requirements
- R1: After reset, the busy flag (bit 25 of the word at offset 0x200) and its low data byte read 0. All chip selects, gb_rd_n and gb_wr_n are high. gb_reg_sel, gb_doe and host_irq are low.
- R2: A host write to offset 0x200 while the bridge is idle sets the busy flag from the next clock onward. The flag stays set for exactly STB_CLKS+2 clocks and then clears.
- R3: A host write to offset 0x200 while the busy flag is set is ignored. This includes a write in the last busy clock. The running cycle keeps its chip, direction, register select and data, and busy clears on schedule.
- R4: During a cycle, only the chip select of the chip named by bit 20 of the command is low. gb_reg_sel equals bit 16 of the command (0 = offset latch, 1 = data register). Both stay valid for every busy clock.
- R5: Bit 23 of the command picks the direction (1 = write, 0 = read). A write cycle holds gb_wr_n low for STB_CLKS clocks and never lowers gb_rd_n. A read cycle does the reverse.
- R6: gb_doe is high, and gb_dout carries bits 7:0 of the command, only during a write cycle. During a read cycle gb_doe is low.
- R7: The byte on gb_din in the last strobe clock of a read cycle appears in bits 7:0 of the word at 0x200 once busy clears. Later write cycles leave it unchanged until the next read completes.
- R8: Any high guest_irq bit sets a sticky flag, seen on host_irq and in bit 0 of the word at 0x3C. Only a write of 0x70000000 to offset 0x3C clears the flag. A request in the same clock as the clear keeps the flag set.
- R9: Host writes to any offset other than 0x200 and 0x3C start no cycle and change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe, one clock per write |
| host_addr | input | 12 | Host byte offset for reads and writes |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Word at host_addr (status at 0x200, interrupt flag at 0x3C) |
| host_irq | output | 1 | Sticky interrupt flag |
| guest_irq | input | 2 | Interrupt requests from the chips |
| gb_cs_n | output | 2 | Active-low chip selects, one per chip |
| gb_reg_sel | output | 1 | 0 = offset latch, 1 = data register |
| gb_rd_n | output | 1 | Active-low read strobe |
| gb_wr_n | output | 1 | Active-low write strobe |
| gb_dout | output | 8 | Byte driven toward the chips |
| gb_doe | output | 1 | Output enable for gb_dout |
| gb_din | input | 8 | Byte returned by the selected chip |

## Verification
Two pairs of events can land in the same clock. The first is a new host command arriving in the final hold clock of a running cycle. The bench injects a second command exactly at the last sample where busy still reads 1, and again in mid-cycle. It judges the result by the busy count, the chip selects and the strobe counts of the original cycle. It also requires busy to read 0 on the very next sample. The second pair is a guest interrupt request and the clearing key write in one clock. The bench drives both together and requires the flag to stay set. A later clear with the request gone must then drop it.

// File: rtl/gxb_pkg.sv
package gxb_pkg;

   localparam int BUSY_BIT   = 25;
   localparam int WRITE_BIT  = 23;
   localparam int GUEST_LSB  = 20;
   localparam int REGSEL_BIT = 16;
   localparam int MAX_GUESTS = 8;
   localparam int GIDX_W     = 3;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_SETUP  = 2'd1,
      SQ_STROBE = 2'd2,
      SQ_HOLD   = 2'd3
   } sq_state_t;

   typedef struct packed {
      logic              write;
      logic              reg_sel;
      logic [GIDX_W-1:0] guest;
      logic [7:0]        data;
   } gcmd_t;

endpackage

// File: rtl/gxb_cmd_decode.sv
module gxb_cmd_decode
   import gxb_pkg::*;
#(
   parameter int          ADDR_W     = 12,
   parameter int          NUM_GUESTS = 2,
   parameter logic [11:0] CMD_OFS    = 12'h200,
   parameter logic [11:0] IRQ_OFS    = 12'h03C,
   parameter logic [31:0] IRQ_KEY    = 32'h7000_0000
)(
   input  logic              host_wr_en,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [31:0]       host_wdata,
   input  logic              busy,
   output logic              cmd_go,
   output gcmd_t             cmd,
   output logic              irq_clr
);

   localparam int GSEL_W = (NUM_GUESTS > 1) ? $clog2(NUM_GUESTS) : 1;

   logic hit_cmd;
   logic hit_irq;

   initial begin
      assert (GSEL_W <= GIDX_W && GUEST_LSB + GSEL_W <= WRITE_BIT)
         else $error("guest select field too wide");
   end

   assign hit_cmd = host_wr_en && (host_addr == ADDR_W'(CMD_OFS));
   assign hit_irq = host_wr_en && (host_addr == ADDR_W'(IRQ_OFS));

   assign cmd_go  = hit_cmd && !busy;
   assign irq_clr = hit_irq && (host_wdata == IRQ_KEY);

   always_comb begin
      cmd         = '0;
      cmd.write   = host_wdata[WRITE_BIT];
      cmd.reg_sel = host_wdata[REGSEL_BIT];
      cmd.guest   = GIDX_W'(host_wdata[GUEST_LSB +: GSEL_W]);
      cmd.data    = host_wdata[7:0];
   end

endmodule

// File: rtl/gxb_sequencer.sv
module gxb_sequencer
   import gxb_pkg::*;
#(
   parameter int NUM_GUESTS = 2,
   parameter int STB_CLKS   = 4
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_go,
   input  gcmd_t                 cmd,
   output logic                  busy,
   output logic [7:0]            rd_byte,
   output logic [NUM_GUESTS-1:0] gb_cs_n,
   output logic                  gb_reg_sel,
   output logic                  gb_rd_n,
   output logic                  gb_wr_n,
   output logic [7:0]            gb_dout,
   output logic                  gb_doe,
   input  logic [7:0]            gb_din
);

   localparam int CNT_W = (STB_CLKS > 1) ? $clog2(STB_CLKS) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STB_CLKS - 1);

   sq_state_t  state;
   logic [CNT_W-1:0] cnt;
   gcmd_t      cmd_q;
   logic [7:0] rdata_q;
   logic       active;
   logic       in_strobe;

   initial begin
      assert (STB_CLKS >= 1) else $error("STB_CLKS must be at least 1");
      assert (NUM_GUESTS >= 1 && NUM_GUESTS <= MAX_GUESTS)
         else $error("NUM_GUESTS out of range");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         cnt     <= '0;
         cmd_q   <= '0;
         rdata_q <= '0;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (cmd_go) begin
                  cmd_q <= cmd;
                  state <= SQ_SETUP;
               end
            end
            SQ_SETUP: begin
               cnt   <= '0;
               state <= SQ_STROBE;
            end
            SQ_STROBE: begin
               if (cnt == CNT_LAST) begin
                  state <= SQ_HOLD;
                  if (!cmd_q.write) rdata_q <= gb_din;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign active    = (state != SQ_IDLE);
   assign in_strobe = (state == SQ_STROBE);
   assign busy      = active;
   assign rd_byte   = rdata_q;

   for (genvar g = 0; g < NUM_GUESTS; g++) begin : g_cs
      assign gb_cs_n[g] = !(active && (cmd_q.guest == GIDX_W'(g)));
   end

   assign gb_reg_sel = active && cmd_q.reg_sel;
   assign gb_rd_n    = !(in_strobe && !cmd_q.write);
   assign gb_wr_n    = !(in_strobe && cmd_q.write);
   assign gb_doe     = active && cmd_q.write;
   assign gb_dout    = gb_doe ? cmd_q.data : 8'h00;

   // R2: an accepted command makes the bridge busy on the next clock
   a_r2_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_go && !busy) |=> busy);

   // R3: the latched command does not move while a cycle runs
   a_r3_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      active |=> $stable(cmd_q));

   // R4: at most one chip selected
   a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~gb_cs_n));

   // R5: strobes never overlap
   a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!gb_rd_n && !gb_wr_n));

   // R6: no drive while reading
   a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !gb_rd_n |-> !gb_doe);

   // R7: returned byte only moves at the end of a read strobe
   a_r7_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_strobe && !cmd_q.write) |=> $stable(rdata_q));

endmodule

// File: rtl/gxb_irq_latch.sv
module gxb_irq_latch #(
   parameter int NUM_GUESTS = 2
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_GUESTS-1:0] guest_irq,
   input  logic                  irq_clr,
   output logic                  irq_flag
);

   logic req;

   assign req = |guest_irq;

   always_ff @(posedge clk) begin
      if (!rst_n)       irq_flag <= 1'b0;
      else if (req)     irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
   end

   // R8: a request wins over a clear in the same clock
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> irq_flag);

   // R8: the flag only drops on a clear
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !irq_clr) |=> irq_flag);

endmodule

// File: rtl/gxb_bridge.sv
module gxb_bridge
   import gxb_pkg::*;
#(
   parameter int          ADDR_W     = 12,
   parameter int          NUM_GUESTS = 2,
   parameter int          STB_CLKS   = 4,
   parameter logic [11:0] CMD_OFS    = 12'h200,
   parameter logic [11:0] IRQ_OFS    = 12'h03C,
   parameter logic [31:0] IRQ_KEY    = 32'h7000_0000
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  host_wr_en,
   input  logic [ADDR_W-1:0]     host_addr,
   input  logic [31:0]           host_wdata,
   output logic [31:0]           host_rdata,
   output logic                  host_irq,
   input  logic [NUM_GUESTS-1:0] guest_irq,
   output logic [NUM_GUESTS-1:0] gb_cs_n,
   output logic                  gb_reg_sel,
   output logic                  gb_rd_n,
   output logic                  gb_wr_n,
   output logic [7:0]            gb_dout,
   output logic                  gb_doe,
   input  logic [7:0]            gb_din
);

   logic       cmd_go;
   gcmd_t      cmd;
   logic       irq_clr;
   logic       busy;
   logic [7:0] rd_byte;
   logic       irq_flag;

   initial begin
      assert (ADDR_W >= 10 && ADDR_W <= 12) else $error("ADDR_W must hold the offsets");
   end

   gxb_cmd_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_GUESTS(NUM_GUESTS),
      .CMD_OFS   (CMD_OFS),
      .IRQ_OFS   (IRQ_OFS),
      .IRQ_KEY   (IRQ_KEY)
   ) i_decode (
      .host_wr_en(host_wr_en),
      .host_addr (host_addr),
      .host_wdata(host_wdata),
      .busy      (busy),
      .cmd_go    (cmd_go),
      .cmd       (cmd),
      .irq_clr   (irq_clr)
   );

   gxb_sequencer #(
      .NUM_GUESTS(NUM_GUESTS),
      .STB_CLKS  (STB_CLKS)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_go    (cmd_go),
      .cmd       (cmd),
      .busy      (busy),
      .rd_byte   (rd_byte),
      .gb_cs_n   (gb_cs_n),
      .gb_reg_sel(gb_reg_sel),
      .gb_rd_n   (gb_rd_n),
      .gb_wr_n   (gb_wr_n),
      .gb_dout   (gb_dout),
      .gb_doe    (gb_doe),
      .gb_din    (gb_din)
   );

   gxb_irq_latch #(
      .NUM_GUESTS(NUM_GUESTS)
   ) i_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .guest_irq(guest_irq),
      .irq_clr  (irq_clr),
      .irq_flag (irq_flag)
   );

   assign host_irq = irq_flag;

   always_comb begin
      host_rdata = '0;
      if (host_addr == ADDR_W'(CMD_OFS)) begin
         host_rdata[BUSY_BIT] = busy;
         host_rdata[7:0]      = rd_byte;
      end else if (host_addr == ADDR_W'(IRQ_OFS)) begin
         host_rdata[0] = irq_flag;
      end
   end

   // R9: writes elsewhere never start a cycle
   a_r9_other_offsets: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr_en && host_addr != ADDR_W'(CMD_OFS) && !busy) |=> !busy);

endmodule

// File: tb/test_gxb_bridge.sv
module test_gxb_bridge;

   localparam int STB = 4;
   localparam logic [11:0] CMD = 12'h200;
   localparam logic [11:0] IRQA = 12'h03C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr_en = 1'b0;
   logic [11:0] host_addr = CMD;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_irq;
   logic [1:0]  guest_irq = 2'b00;
   logic [1:0]  gb_cs_n;
   logic        gb_reg_sel, gb_rd_n, gb_wr_n, gb_doe;
   logic [7:0]  gb_dout;
   logic [7:0]  gb_din;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 0;

   logic [7:0] gmem [2][128];
   logic [6:0] gaddr [2];
   logic [7:0] shadow [2][128];

   always #4 clk = ~clk;

   gxb_bridge #(.STB_CLKS(STB)) i_gxb_bridge (
      .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
      .guest_irq(guest_irq), .gb_cs_n(gb_cs_n), .gb_reg_sel(gb_reg_sel),
      .gb_rd_n(gb_rd_n), .gb_wr_n(gb_wr_n), .gb_dout(gb_dout), .gb_doe(gb_doe),
      .gb_din(gb_din)
   );

   // peripheral chip model: offset latch plus 128 byte registers each
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int g = 0; g < 2; g++) begin
            gaddr[g] <= '0;
            for (int a = 0; a < 128; a++) gmem[g][a] <= 8'h00;
         end
      end else if (!gb_wr_n) begin
         for (int g = 0; g < 2; g++) begin
            if (!gb_cs_n[g]) begin
               if (!gb_reg_sel) gaddr[g] <= gb_dout[6:0];
               else             gmem[g][gaddr[g]] <= gb_dout;
            end
         end
      end
   end

   always_comb begin
      gb_din = 8'h00;
      for (int g = 0; g < 2; g++)
         if (!gb_cs_n[g] && !gb_rd_n) gb_din = gmem[g][gaddr[g]];
   end

   function automatic logic [31:0] mk_cmd(input bit wr, input int g, input bit rsel, input logic [7:0] d);
      return (32'(wr) << 23) | (32'(g) << 20) | (32'(rsel) << 16) | 32'(d);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic run_cmd(input logic [31:0] word, input int inj_at, input logic [31:0] inj_word,
                          output logic [7:0] rbyte);
      int nb = 0, nw = 0, nr = 0;
      bit cs_bad = 0, reg_bad = 0, doe_bad = 0;
      bit wr = word[23];
      int g = int'(word[20]);
      logic [1:0] cs_exp = (g == 0) ? 2'b10 : 2'b01;
      @(negedge clk);
      host_addr = CMD; host_wdata = word; host_wr_en = 1'b1;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         host_wr_en = (i == inj_at);
         if (i == inj_at) host_wdata = inj_word;
         if (!host_rdata[25]) break;
         nb++;
         if (gb_cs_n != cs_exp) cs_bad = 1;
         if (gb_reg_sel != word[16]) reg_bad = 1;
         if (!gb_wr_n) nw++;
         if (!gb_rd_n) nr++;
         if (gb_doe != wr || (wr && gb_dout != word[7:0])) doe_bad = 1;
      end
      host_wr_en = 1'b0;
      rbyte = host_rdata[7:0];
      chk(nb == STB + 2, "R2", "busy clocks", 32'(nb), 32'(STB + 2));
      chk(!cs_bad, "R4", "chip select", 32'(cs_bad), 0);
      chk(!reg_bad, "R4", "register select", 32'(reg_bad), 0);
      chk(nw == (wr ? STB : 0), "R5", "write strobe clocks", 32'(nw), wr ? STB : 0);
      chk(nr == (wr ? 0 : STB), "R5", "read strobe clocks", 32'(nr), wr ? 0 : STB);
      chk(!doe_bad, "R6", "data drive", 32'(doe_bad), 0);
   endtask

   task automatic reg_write(input int g, input logic [6:0] off, input logic [7:0] d);
      logic [7:0] rb;
      run_cmd(mk_cmd(1, g, 0, {1'b0, off}), -1, 0, rb);
      run_cmd(mk_cmd(1, g, 1, d), -1, 0, rb);
      shadow[g][off] = d;
   endtask

   task automatic reg_read(input int g, input logic [6:0] off, output logic [7:0] rb);
      logic [7:0] tmp;
      run_cmd(mk_cmd(1, g, 0, {1'b0, off}), -1, 0, tmp);
      run_cmd(mk_cmd(0, g, 1, 8'h00), -1, 0, rb);
      chk(rb == shadow[g][off], "R7", "read byte", 32'(rb), 32'(shadow[g][off]));
   endtask

   task automatic host_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr_en = 1'b1;
      @(negedge clk);
      host_wr_en = 1'b0;
   endtask

   initial begin
      logic [7:0] rb, rb2;
      void'($urandom(32'd20240611));
      for (int g = 0; g < 2; g++)
         for (int a = 0; a < 128; a++) shadow[g][a] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(host_rdata == 32'h0, "R1", "status word", host_rdata, 0);
      chk(gb_cs_n == 2'b11 && gb_rd_n && gb_wr_n, "R1", "bus strobes",
          {28'h0, gb_cs_n, gb_rd_n, gb_wr_n}, 32'hF);
      chk(!gb_doe && !gb_reg_sel && !host_irq, "R1", "enables",
          {29'h0, gb_doe, gb_reg_sel, host_irq}, 0);

      // directed: FIFO offsets, channel B via +0x40
      reg_write(0, 7'h1E, 8'hA5);
      reg_write(1, 7'h1F, 8'h3C);
      reg_write(1, 7'h5F, 8'hC3);
      reg_read(1, 7'h5F, rb);
      reg_read(1, 7'h1F, rb);
      reg_read(0, 7'h1E, rb);

      // R7: a later write leaves the returned byte alone
      reg_write(1, 7'h02, 8'h77);
      host_addr = CMD;
      chk(host_rdata[7:0] == 8'hA5, "R7", "held byte", 32'(host_rdata[7:0]), 32'hA5);

      // R3: mid-cycle injection to the other chip
      run_cmd(mk_cmd(1, 0, 0, 8'h05), 1, mk_cmd(1, 1, 1, 8'hEE), rb);
      // R3: injection in the last busy clock
      run_cmd(mk_cmd(1, 0, 1, 8'h5A), STB + 1, mk_cmd(0, 1, 0, 8'h00), rb);
      shadow[0][7'h05] = 8'h5A;
      @(negedge clk);
      chk(!host_rdata[25] && gb_cs_n == 2'b11, "R3", "late command ignored",
          {host_rdata[25], 29'h0, gb_cs_n}, 32'h3);
      reg_read(0, 7'h05, rb);
      reg_read(1, 7'h02, rb);

      // R9: write elsewhere
      host_write(12'h204, mk_cmd(1, 0, 1, 8'h11));
      host_addr = CMD;
      chk(!host_rdata[25] && gb_cs_n == 2'b11 && gb_wr_n, "R9", "stray write",
          {host_rdata[25], 28'h0, gb_cs_n, gb_wr_n}, 32'h7);

      // R8 interrupt latch
      @(negedge clk); guest_irq = 2'b01;
      @(negedge clk); guest_irq = 2'b00;
      chk(host_irq, "R8", "flag set", 32'(host_irq), 1);
      host_write(IRQA, 32'h7000_0001);
      chk(host_irq, "R8", "wrong key keeps flag", 32'(host_irq), 1);
      host_write(IRQA, 32'h7000_0000);
      chk(!host_irq, "R8", "key clears flag", 32'(host_irq), 0);
      @(negedge clk);
      guest_irq = 2'b10; host_addr = IRQA; host_wdata = 32'h7000_0000; host_wr_en = 1'b1;
      @(negedge clk);
      host_wr_en = 1'b0; guest_irq = 2'b00;
      chk(host_irq && host_rdata[0], "R8", "request beats clear",
          {30'h0, host_irq, host_rdata[0]}, 32'h3);
      host_write(IRQA, 32'h7000_0000);
      chk(!host_irq, "R8", "clear after request gone", 32'(host_irq), 0);

      // constrained random accesses
      for (int k = 0; k < 30; k++) begin
         int g = int'($urandom_range(1, 0));
         logic [6:0] off = (g == 0) ? 7'($urandom_range(63, 0)) : 7'($urandom_range(127, 0));
         logic [7:0] d = 8'($urandom);
         reg_write(g, off, d);
         if ($urandom_range(1, 0) == 1) reg_read(g, off, rb2);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule